// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This unit decides where instruction fetch goes next in a 32-bit RISC core whose control transfers have a single delay slot. Each cycle in which `step_i` is high, the core presents one decoded instruction: its address, the opcode, rt, rd and function fields, the 16-bit offset, the 26-bit jump index and the two register operands. The unit classifies the instruction, evaluates its condition and forms the destination address. The result appears on registered outputs one clock later.

The unit does not redirect fetch at once. A taken transfer is held as a pending redirect, and the next-fetch address moves to the destination only when the following instruction, the delay slot, is stepped. The delay-slot instruction therefore always executes. Calls report a link write of the address after the delay slot. Each decision is a one-cycle pulse. Addresses and link fields hold their values between steps.

Top module: `next_pc_unit`

## Requirements
- R1: After a synchronous active-high reset, `next_pc_o` equals the RESET_PC parameter (default 0x0000_1000). `taken_o`, `link_we_o`, `target_o`, `link_val_o` and `link_reg_o` are all zero.
- R2: Conditional branches compare rs as a signed value. Opcode 4 branches when rs equals rt, opcode 5 when rs differs from rt, opcode 6 when rs <= 0 and opcode 7 when rs > 0.
- R3: Opcode 1 picks its test from the rt field. rt=0 branches when rs < 0 and rt=1 when rs >= 0. rt=16 and rt=17 apply the same two tests and also link. Any other rt value is not a control transfer.
- R4: A branch destination is PC+4 plus the sign-extended 16-bit offset shifted left by two.
- R5: Opcode 2 (jump) and opcode 3 (jump with link) always transfer. Their destination is the top 4 bits of PC+4, then the 26-bit index, then two zero bits.
- R6: Opcode 0 with function 8 always transfers to the address in rs. Function 9 does the same and also links into register rd.
- R7: Every step loads `link_val_o` with PC+8. Linking instructions pulse `link_we_o`. `link_reg_o` is 31 for every linking instruction except opcode 0 / function 9, where it is rd. The rt=16 and rt=17 branches link whether or not they are taken.
- R8: `taken_o`, `target_o` and `link_we_o` reflect the instruction stepped on the previous clock edge. `taken_o` and `link_we_o` are high for one cycle only.
- R9: A step with no pending redirect sets `next_pc_o` to PC+4. The step after a taken transfer (its delay slot) sets `next_pc_o` to that transfer's destination.
- R10: While `step_i` is low, `next_pc_o`, `target_o`, `link_reg_o` and `link_val_o` hold their values, and `taken_o` and `link_we_o` stay low.
- R11: A taken transfer stepped in a delay slot sends fetch first to the earlier destination. The next step then goes to its own destination.
- R12: A step that is not a control transfer gives `taken_o`=0, `target_o`=0 and `link_we_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | An instruction is presented this cycle |
| pc_i | input | 32 | Address of the presented instruction |
| opcode_i | input | 6 | Major opcode field |
| rt_sel_i | input | 5 | rt field (also selects opcode-1 tests) |
| rd_sel_i | input | 5 | rd field (link register of function 9) |
| funct_i | input | 6 | Function code for opcode 0 |
| offset_i | input | 16 | Branch offset in words |
| index_i | input | 26 | Jump index in words |
| rs_val_i | input | 32 | Value of register rs |
| rt_val_i | input | 32 | Value of register rt |
| taken_o | output | 1 | Stepped instruction transfers control |
| target_o | output | 32 | Destination of a taken transfer, else zero |
| link_we_o | output | 1 | Write link value this cycle |
| link_reg_o | output | 5 | Register receiving the link value |
| link_val_o | output | 32 | Address after the delay slot (PC+8) |
| next_pc_o | output | 32 | Address to fetch next |

## Verification
The hardest states to reach are a taken transfer stepped inside another transfer's delay slot, and a linking branch that is not taken yet must still write its link. Both need a chosen run of steps, not a single instruction. The bench steps a taken equal-branch and follows it at once with a jump in its delay slot. It then walks two further steps to watch fetch go to each destination in turn. For the second case it gives the rt=16 test a positive operand, so the link write appears with `taken_o` low.

// File: rtl/next_pc_pkg.sv
package next_pc_pkg;

  typedef enum logic [1:0] {
    XFER_NONE,
    XFER_BRANCH,
    XFER_JUMP,
    XFER_REG
  } xfer_kind_e;

  typedef enum logic [2:0] {
    TEST_NEVER,
    TEST_ALWAYS,
    TEST_EQ,
    TEST_NE,
    TEST_LEZ,
    TEST_GTZ,
    TEST_LTZ,
    TEST_GEZ
  } test_e;

  typedef struct packed {
    xfer_kind_e kind;
    test_e      test;
    logic       links;
    logic       link_to_rd;
  } xfer_dec_t;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_REGIMM  = 6'd1;
  localparam logic [5:0] OP_JUMP    = 6'd2;
  localparam logic [5:0] OP_JLINK   = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_BLEZ    = 6'd6;
  localparam logic [5:0] OP_BGTZ    = 6'd7;

  localparam logic [5:0] FN_JREG    = 6'd8;
  localparam logic [5:0] FN_JREGLNK = 6'd9;

  localparam logic [4:0] RI_LTZ     = 5'd0;
  localparam logic [4:0] RI_GEZ     = 5'd1;
  localparam logic [4:0] RI_LTZ_LNK = 5'd16;
  localparam logic [4:0] RI_GEZ_LNK = 5'd17;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import next_pc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [4:0] rt_sel_i,
  input  logic [5:0] funct_i,
  output xfer_dec_t  dec_o
);

  always_comb begin
    dec_o.kind       = XFER_NONE;
    dec_o.test       = TEST_NEVER;
    dec_o.links      = 1'b0;
    dec_o.link_to_rd = 1'b0;
    unique case (opcode_i)
      OP_SPECIAL: begin
        if (funct_i == FN_JREG || funct_i == FN_JREGLNK) begin
          dec_o.kind = XFER_REG;
          dec_o.test = TEST_ALWAYS;
          if (funct_i == FN_JREGLNK) begin
            dec_o.links      = 1'b1;
            dec_o.link_to_rd = 1'b1;
          end
        end
      end
      OP_REGIMM: begin
        unique case (rt_sel_i)
          RI_LTZ: begin
            dec_o.kind = XFER_BRANCH;
            dec_o.test = TEST_LTZ;
          end
          RI_GEZ: begin
            dec_o.kind = XFER_BRANCH;
            dec_o.test = TEST_GEZ;
          end
          RI_LTZ_LNK: begin
            dec_o.kind  = XFER_BRANCH;
            dec_o.test  = TEST_LTZ;
            dec_o.links = 1'b1;
          end
          RI_GEZ_LNK: begin
            dec_o.kind  = XFER_BRANCH;
            dec_o.test  = TEST_GEZ;
            dec_o.links = 1'b1;
          end
          default: ;
        endcase
      end
      OP_JUMP: begin
        dec_o.kind = XFER_JUMP;
        dec_o.test = TEST_ALWAYS;
      end
      OP_JLINK: begin
        dec_o.kind  = XFER_JUMP;
        dec_o.test  = TEST_ALWAYS;
        dec_o.links = 1'b1;
      end
      OP_BEQ: begin
        dec_o.kind = XFER_BRANCH;
        dec_o.test = TEST_EQ;
      end
      OP_BNE: begin
        dec_o.kind = XFER_BRANCH;
        dec_o.test = TEST_NE;
      end
      OP_BLEZ: begin
        dec_o.kind = XFER_BRANCH;
        dec_o.test = TEST_LEZ;
      end
      OP_BGTZ: begin
        dec_o.kind = XFER_BRANCH;
        dec_o.test = TEST_GTZ;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import next_pc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  test_e            test_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  output logic             take_o
);

  logic rs_neg;
  logic rs_zero;
  logic ops_equal;

  assign rs_neg    = rs_val_i[XLEN-1];
  assign rs_zero   = (rs_val_i == '0);
  assign ops_equal = (rs_val_i == rt_val_i);

  always_comb begin
    unique case (test_i)
      TEST_ALWAYS: take_o = 1'b1;
      TEST_EQ:     take_o = ops_equal;
      TEST_NE:     take_o = !ops_equal;
      TEST_LEZ:    take_o = rs_neg || rs_zero;
      TEST_GTZ:    take_o = !rs_neg && !rs_zero;
      TEST_LTZ:    take_o = rs_neg;
      TEST_GEZ:    take_o = !rs_neg;
      default:     take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import next_pc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  xfer_kind_e       kind_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic [XLEN-1:0]  rs_val_i,
  output logic [XLEN-1:0]  seq_pc_o,
  output logic [XLEN-1:0]  dest_o,
  output logic [XLEN-1:0]  link_val_o
);

  localparam int EXT_W    = XLEN - OFF_W - 2;
  localparam int REGION_W = XLEN - IDX_W - 2;

  logic [XLEN-1:0] br_disp;
  logic [XLEN-1:0] jmp_dest;

  assign seq_pc_o   = pc_i + XLEN'(4);
  assign link_val_o = pc_i + XLEN'(8);
  assign br_disp    = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};

  generate
    if (REGION_W > 0) begin : g_region
      assign jmp_dest = {seq_pc_o[XLEN-1 -: REGION_W], index_i, 2'b00};
    end else begin : g_flat
      assign jmp_dest = XLEN'({index_i, 2'b00});
    end
  endgenerate

  always_comb begin
    unique case (kind_i)
      XFER_BRANCH: dest_o = seq_pc_o + br_disp;
      XFER_JUMP:   dest_o = jmp_dest;
      XFER_REG:    dest_o = rs_val_i;
      default:     dest_o = '0;
    endcase
  end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import next_pc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OFF_W    = 16,
  parameter int          IDX_W    = 26,
  parameter int          REG_W    = 5,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [31:0]      pc_i,
  input  logic [5:0]       opcode_i,
  input  logic [4:0]       rt_sel_i,
  input  logic [4:0]       rd_sel_i,
  input  logic [5:0]       funct_i,
  input  logic [15:0]      offset_i,
  input  logic [25:0]      index_i,
  input  logic [31:0]      rs_val_i,
  input  logic [31:0]      rt_val_i,
  output logic             taken_o,
  output logic [31:0]      target_o,
  output logic             link_we_o,
  output logic [4:0]       link_reg_o,
  output logic [31:0]      link_val_o,
  output logic [31:0]      next_pc_o
);

  localparam logic [REG_W-1:0] LINK_REG = {REG_W{1'b1}};

  xfer_dec_t        dec;
  logic             take_c;
  logic [XLEN-1:0]  seq_pc_c;
  logic [XLEN-1:0]  dest_c;
  logic [XLEN-1:0]  link_val_c;

  logic             pend_q;
  logic [XLEN-1:0]  pend_tgt_q;

  npc_decode u_decode (
    .opcode_i (opcode_i),
    .rt_sel_i (rt_sel_i),
    .funct_i  (funct_i),
    .dec_o    (dec)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .test_i   (dec.test),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .take_o   (take_c)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_target (
    .kind_i     (dec.kind),
    .pc_i       (pc_i),
    .offset_i   (offset_i),
    .index_i    (index_i),
    .rs_val_i   (rs_val_i),
    .seq_pc_o   (seq_pc_c),
    .dest_o     (dest_c),
    .link_val_o (link_val_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o    <= 1'b0;
      target_o   <= '0;
      link_we_o  <= 1'b0;
      link_reg_o <= '0;
      link_val_o <= '0;
      next_pc_o  <= RESET_PC;
      pend_q     <= 1'b0;
      pend_tgt_q <= '0;
    end else begin
      taken_o   <= step_i && take_c;
      link_we_o <= step_i && dec.links;
      if (step_i) begin
        target_o   <= take_c ? dest_c : '0;
        link_reg_o <= dec.link_to_rd ? rd_sel_i : LINK_REG;
        link_val_o <= link_val_c;
        next_pc_o  <= pend_q ? pend_tgt_q : seq_pc_c;
        pend_q     <= take_c;
        pend_tgt_q <= dest_c;
      end
    end
  end

  assert_delay_slot_redirect_R9: assert property (@(posedge clk) disable iff (rst)
    (step_i && pend_q) |=> (next_pc_o == $past(pend_tgt_q)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> ($stable(next_pc_o) && $stable(target_o) && !taken_o && !link_we_o));

  assert_link_only_on_step_R8: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> $past(step_i));

  assert_taken_needs_xfer_R12: assert property (@(posedge clk) disable iff (rst)
    (step_i && take_c) |-> (dec.kind != XFER_NONE));

endmodule

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        step_i;
  logic [31:0] pc_i;
  logic [5:0]  opcode_i;
  logic [4:0]  rt_sel_i;
  logic [4:0]  rd_sel_i;
  logic [5:0]  funct_i;
  logic [15:0] offset_i;
  logic [25:0] index_i;
  logic [31:0] rs_val_i;
  logic [31:0] rt_val_i;
  logic        taken_o;
  logic [31:0] target_o;
  logic        link_we_o;
  logic [4:0]  link_reg_o;
  logic [31:0] link_val_o;
  logic [31:0] next_pc_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  next_pc_unit i_next_pc_unit (
    .clk(clk), .rst(rst), .step_i(step_i), .pc_i(pc_i),
    .opcode_i(opcode_i), .rt_sel_i(rt_sel_i), .rd_sel_i(rd_sel_i),
    .funct_i(funct_i), .offset_i(offset_i), .index_i(index_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .taken_o(taken_o), .target_o(target_o), .link_we_o(link_we_o),
    .link_reg_o(link_reg_o), .link_val_o(link_val_o), .next_pc_o(next_pc_o)
  );

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one instruction for one clock; return at the following falling edge.
  task automatic step(logic [31:0] pc, logic [5:0] op, logic [4:0] rt, logic [4:0] rd,
                      logic [5:0] fn, logic [15:0] off, logic [25:0] idx,
                      logic [31:0] rsv, logic [31:0] rtv);
    step_i = 1'b1; pc_i = pc; opcode_i = op; rt_sel_i = rt; rd_sel_i = rd;
    funct_i = fn; offset_i = off; index_i = idx; rs_val_i = rsv; rt_val_i = rtv;
    @(posedge clk);
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Plain instruction used as a delay slot / filler (opcode 8 is no transfer).
  task automatic filler(logic [31:0] pc);
    step(pc, 6'd8, 5'd0, 5'd0, 6'd0, 16'h0000, 26'h0, 32'h0, 32'h0);
  endtask

  // One control instruction, then its delay slot; checks both results.
  task automatic xfer_case(string req, logic [31:0] pc, logic [5:0] op, logic [4:0] rt,
                           logic [4:0] rd, logic [5:0] fn, logic [15:0] off,
                           logic [25:0] idx, logic [31:0] rsv, logic [31:0] rtv,
                           bit exp_take, logic [31:0] exp_tgt, bit exp_lwe,
                           logic [4:0] exp_lreg);
    step(pc, op, rt, rd, fn, off, idx, rsv, rtv);
    cmp(req, "taken", 32'(taken_o), 32'(exp_take));
    cmp(req, "target", target_o, exp_take ? exp_tgt : 32'h0);
    cmp(req, "link_we", 32'(link_we_o), 32'(exp_lwe));
    if (exp_lwe) cmp(req, "link_reg", 32'(link_reg_o), 32'(exp_lreg));
    cmp(req, "link_val", link_val_o, pc + 32'd8);
    cmp(req, "next_pc at branch", next_pc_o, pc + 32'd4);
    filler(pc + 32'd4);
    cmp("R9", "next_pc at delay slot", next_pc_o, exp_take ? exp_tgt : pc + 32'd8);
    cmp("R8", "taken pulse ends", 32'(taken_o), 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1; step_i = 1'b0; pc_i = '0; opcode_i = '0; rt_sel_i = '0; rd_sel_i = '0;
    funct_i = '0; offset_i = '0; index_i = '0; rs_val_i = '0; rt_val_i = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    cmp("R1", "next_pc", next_pc_o, 32'h0000_1000);
    cmp("R1", "taken", 32'(taken_o), 32'd0);
    cmp("R1", "link_we", 32'(link_we_o), 32'd0);
    cmp("R1", "target", target_o, 32'd0);
    cmp("R1", "link_val", link_val_o, 32'd0);
    cmp("R1", "link_reg", 32'(link_reg_o), 32'd0);
  endtask

  task automatic t_plain_R12;
    filler(32'h0040_0000);
    cmp("R12", "taken", 32'(taken_o), 32'd0);
    cmp("R12", "target", target_o, 32'd0);
    cmp("R12", "link_we", 32'(link_we_o), 32'd0);
    cmp("R9", "next_pc seq", next_pc_o, 32'h0040_0004);
  endtask

  task automatic t_two_reg_R2_R4;
    xfer_case("R2", 32'h0040_0100, 6'd4, 5'd0, 5'd0, 6'd0, 16'h0010, 26'h0, 32'd5, 32'd5, 1, 32'h0040_0144, 0, 5'd0);
    xfer_case("R2", 32'h0040_0100, 6'd4, 5'd0, 5'd0, 6'd0, 16'h0010, 26'h0, 32'd5, 32'd6, 0, 32'h0, 0, 5'd0);
    xfer_case("R4", 32'h0040_0200, 6'd5, 5'd0, 5'd0, 6'd0, 16'hFFF0, 26'h0, 32'd1, 32'd2, 1, 32'h0040_01C4, 0, 5'd0);
    xfer_case("R2", 32'h0040_0200, 6'd5, 5'd0, 5'd0, 6'd0, 16'hFFF0, 26'h0, 32'd7, 32'd7, 0, 32'h0, 0, 5'd0);
  endtask

  task automatic t_zero_tests_R2;
    xfer_case("R2", 32'h0000_2000, 6'd6, 5'd0, 5'd0, 6'd0, 16'h0001, 26'h0, 32'd0, 32'd0, 1, 32'h0000_2008, 0, 5'd0);
    xfer_case("R2", 32'h0000_2000, 6'd6, 5'd0, 5'd0, 6'd0, 16'h0001, 26'h0, 32'hFFFF_FFFF, 32'd0, 1, 32'h0000_2008, 0, 5'd0);
    xfer_case("R2", 32'h0000_2000, 6'd6, 5'd0, 5'd0, 6'd0, 16'h0001, 26'h0, 32'd1, 32'd0, 0, 32'h0, 0, 5'd0);
    xfer_case("R2", 32'h0000_2000, 6'd7, 5'd0, 5'd0, 6'd0, 16'h0002, 26'h0, 32'd1, 32'd0, 1, 32'h0000_200C, 0, 5'd0);
    xfer_case("R2", 32'h0000_2000, 6'd7, 5'd0, 5'd0, 6'd0, 16'h0002, 26'h0, 32'h8000_0000, 32'd0, 0, 32'h0, 0, 5'd0);
    xfer_case("R2", 32'h0000_2000, 6'd7, 5'd0, 5'd0, 6'd0, 16'h0002, 26'h0, 32'd0, 32'd0, 0, 32'h0, 0, 5'd0);
  endtask

  task automatic t_regimm_R3_R7;
    xfer_case("R3", 32'h0000_3000, 6'd1, 5'd0, 5'd0, 6'd0, 16'h0004, 26'h0, 32'hFFFF_FFFB, 32'd0, 1, 32'h0000_3014, 0, 5'd0);
    xfer_case("R3", 32'h0000_3000, 6'd1, 5'd0, 5'd0, 6'd0, 16'h0004, 26'h0, 32'd0, 32'd0, 0, 32'h0, 0, 5'd0);
    xfer_case("R3", 32'h0000_3000, 6'd1, 5'd1, 5'd0, 6'd0, 16'h0004, 26'h0, 32'd0, 32'd0, 1, 32'h0000_3014, 0, 5'd0);
    xfer_case("R7", 32'h0000_3000, 6'd1, 5'd16, 5'd0, 6'd0, 16'h0004, 26'h0, 32'd3, 32'd0, 0, 32'h0, 1, 5'd31);
    xfer_case("R7", 32'h0000_3000, 6'd1, 5'd17, 5'd0, 6'd0, 16'h0004, 26'h0, 32'd3, 32'd0, 1, 32'h0000_3014, 1, 5'd31);
    xfer_case("R3", 32'h0000_3000, 6'd1, 5'd2, 5'd0, 6'd0, 16'h0004, 26'h0, 32'hFFFF_FFFF, 32'd0, 0, 32'h0, 0, 5'd0);
  endtask

  task automatic t_jumps_R5;
    xfer_case("R5", 32'h9000_0000, 6'd2, 5'd0, 5'd0, 6'd0, 16'h0, 26'h0123456, 32'd0, 32'd0, 1, 32'h9048_D158, 0, 5'd0);
    xfer_case("R5", 32'h1FFF_FFFC, 6'd3, 5'd0, 5'd0, 6'd0, 16'h0, 26'h3FFFFFF, 32'd0, 32'd0, 1, 32'h2FFF_FFFC, 1, 5'd31);
  endtask

  task automatic t_regjump_R6;
    xfer_case("R6", 32'h0000_4000, 6'd0, 5'd0, 5'd0, 6'd8, 16'h0, 26'h0, 32'h00AB_CDE0, 32'd0, 1, 32'h00AB_CDE0, 0, 5'd0);
    xfer_case("R6", 32'h0000_4000, 6'd0, 5'd0, 5'd7, 6'd9, 16'h0, 26'h0, 32'h0000_1230, 32'd0, 1, 32'h0000_1230, 1, 5'd7);
    xfer_case("R12", 32'h0000_4000, 6'd0, 5'd0, 5'd7, 6'd10, 16'h0, 26'h0, 32'h0000_1230, 32'd0, 0, 32'h0, 0, 5'd0);
  endtask

  task automatic t_hold_R10;
    step(32'h0000_5000, 6'd3, 5'd0, 5'd0, 6'd0, 16'h0, 26'h0000040, 32'd0, 32'd0);
    cmp("R8", "link_we pulse", 32'(link_we_o), 32'd1);
    idle(3);
    cmp("R10", "next_pc held", next_pc_o, 32'h0000_5004);
    cmp("R10", "target held", target_o, 32'h0000_0100);
    cmp("R10", "link_val held", link_val_o, 32'h0000_5008);
    cmp("R10", "link_reg held", 32'(link_reg_o), 32'd31);
    cmp("R10", "taken low", 32'(taken_o), 32'd0);
    cmp("R10", "link_we low", 32'(link_we_o), 32'd0);
    filler(32'h0000_5004);
    cmp("R9", "redirect after idle gap", next_pc_o, 32'h0000_0100);
  endtask

  task automatic t_nested_R11;
    // equal-branch at 0x300 -> 0x314, jump in its delay slot -> 0x00000800
    step(32'h0040_0300, 6'd4, 5'd0, 5'd0, 6'd0, 16'h0004, 26'h0, 32'd9, 32'd9);
    cmp("R11", "next_pc after first", next_pc_o, 32'h0040_0304);
    step(32'h0040_0304, 6'd2, 5'd0, 5'd0, 6'd0, 16'h0, 26'h0000200, 32'd0, 32'd0);
    cmp("R11", "taken of slot jump", 32'(taken_o), 32'd1);
    cmp("R11", "next_pc to first target", next_pc_o, 32'h0040_0314);
    filler(32'h0040_0314);
    cmp("R11", "next_pc to second target", next_pc_o, 32'h0000_0800);
    filler(32'h0000_0800);
    cmp("R11", "sequential again", next_pc_o, 32'h0000_0804);
  endtask

  initial begin
    t_reset;
    t_plain_R12;
    t_two_reg_R2_R4;
    t_zero_tests_R2;
    t_regimm_R3_R7;
    t_jumps_R5;
    t_regjump_R6;
    t_hold_R10;
    t_nested_R11;
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule